// File: doc/BRIEF.md
# Level-Shifted Multicarrier PWM Modulator

This block produces the switching decisions for an odd-level cascaded bridge inverter. It keeps one digital triangle per carrier, `LEVELS-1` carriers in all, and stacks them on top of each other. Every carrier has the same height, and each one sits in its own band of the signed reference range. The bands touch but do not overlap. A signed reference sample arrives each clock from an external sine source. Each comparator bit is set while that sample lies strictly above its carrier. A signed level code is derived from the comparator bits and gives the output step that the cascaded cells should now produce.

A two-bit mode input selects how the carriers relate in phase:
- all carriers in phase;
- the lower half inverted against the upper half;
- every carrier inverted against its neighbour;
- a variable-frequency arrangement in which symmetric pairs of bands share a rate and outer pairs run slower, which evens out the switching counts.

A new mode is taken over only at the end of a carrier frame. At that point every triangle restarts from the start state of the new mode, so no short pulse appears.

Top module: `lvlshift_pwm`

## Requirements
- R1: While reset is asserted, and directly after its release, every bit of `cmp_o` is 0 and `level_o` equals -(LEVELS-1)/2.
- R2: `cmp_o[k]` is 1 in the cycle after a clock edge exactly when the `ref_smp` sampled at that edge is greater (signed) than carrier k as it stood before that edge. Equality gives 0.
- R3: Carrier k equals (k - HALF)*CAR_MAX + t_k, where HALF=(LEVELS-1)/2 and the triangle value t_k lies in 0..CAR_MAX. Therefore `cmp_o` is always a thermometer code, filled from bit 0 upward. A reference above HALF*CAR_MAX gives all ones, and a reference at or below -HALF*CAR_MAX gives all zeros.
- R4: `level_o` equals the number of set bits of `cmp_o` minus HALF.
- R5: Timing. A step tick occurs on every PRESC-th clock edge after reset. A frame lasts FRAME = 2*CAR_MAX*2^(HALF-1) ticks. A triangle moves by 1 on each step, going 0 up to CAR_MAX and back, so one period is 2*CAR_MAX steps. In mode_sel=0 (in phase), every carrier starts a frame at t=0 rising and steps on every tick.
- R6: mode_sel=1 (opposed about zero): carriers k < HALF start a frame at t=CAR_MAX falling, so t_k = CAR_MAX minus the in-phase value. Carriers k >= HALF behave as in R5.
- R7: mode_sel=2 (alternate opposition): odd-indexed carriers are inverted as in R6, and even-indexed carriers behave as in R5.
- R8: mode_sel=3 (variable frequency): all carriers start in phase. Carrier k has distance d = HALF-1-k for k < HALF and d = k-HALF otherwise. It steps only on ticks whose in-frame tick index is a multiple of 2^d. Pairs with equal d therefore share a frequency, and the outermost pair is the slowest.
- R9: The active mode is loaded from `mode_sel` only on the edge that ends a frame, and all triangles restart on that edge in the start state of the new mode. A change of `mode_sel` at any other time has no effect until then. After reset the active mode is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_sel | input | 2 | Requested carrier arrangement (0 in phase, 1 opposed about zero, 2 alternate, 3 variable frequency) |
| ref_smp | input | REF_W | Signed reference sample |
| cmp_o | output | LEVELS-1 | Comparator bits, bit k for carrier k (bit 0 lowest band) |
| level_o | output | clog2(HALF+1)+1 | Signed output level code |

## Verification
Two events can fall in the same cycle. The first is a frame end, where the mode is swapped and every triangle reloads. The second is a comparator decision made against the carrier values from the cycle before. The bench changes the mode request in the cycle just before a frame-end edge, and also in the middle of a frame, while the reference ramps through every band. It judges each cycle's comparator bits and level code against a model built from the requirements. That model computes each carrier from the tick count since the last frame start, with no step-by-step counter, so a reload taken one cycle early or late shows up as a wrong bit pattern.

// File: rtl/lvlshift_pwm_pkg.sv
package lvlshift_pwm_pkg;

  typedef enum logic [1:0] {
    MODE_PD   = 2'd0,
    MODE_POD  = 2'd1,
    MODE_APOD = 2'd2,
    MODE_VSF  = 2'd3
  } carmode_e;

  // Whether carrier idx starts its frame at the top of its band, falling.
  function automatic logic phase_inverted(carmode_e m, int idx, int half);
    case (m)
      MODE_POD:  return (idx < half);
      MODE_APOD: return ((idx % 2) == 1);
      default:   return 1'b0;
    endcase
  endfunction

  // Distance of a band from the centre pair, 0 for the innermost pair.
  function automatic int band_distance(int idx, int half);
    return (idx < half) ? (half - 1 - idx) : (idx - half);
  endfunction

endpackage

// File: rtl/lvlshift_pwm_tick.sv
module lvlshift_pwm_tick #(
  parameter int PRESC = 2,
  parameter int FRAME = 128,
  parameter int PW    = 1,
  parameter int FW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          tick_o,
  output logic          frame_end_o,
  output logic [FW-1:0] frame_pos_o
);

  logic [PW-1:0] pcnt_q, pcnt_n;
  logic [FW-1:0] fcnt_q, fcnt_n;

  assign tick_o      = (pcnt_q == PW'(PRESC - 1));
  assign frame_end_o = tick_o && (fcnt_q == FW'(FRAME - 1));
  assign frame_pos_o = fcnt_q;

  always_comb begin
    pcnt_n = pcnt_q;
    fcnt_n = fcnt_q;
    if (tick_o) begin
      pcnt_n = '0;
      if (frame_end_o) fcnt_n = '0;
      else             fcnt_n = fcnt_q + FW'(1);
    end else begin
      pcnt_n = pcnt_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      fcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_n;
      fcnt_q <= fcnt_n;
    end
  end

endmodule

// File: rtl/lvlshift_pwm_carrier.sv
module lvlshift_pwm_carrier
  import lvlshift_pwm_pkg::*;
#(
  parameter int IDX     = 0,
  parameter int HALF    = 3,
  parameter int CAR_MAX = 16,
  parameter int CW      = 5,
  parameter int FW      = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          frame_end_i,
  input  logic [FW-1:0] frame_pos_i,
  input  carmode_e      mode_act_i,
  input  carmode_e      mode_nxt_i,
  output logic [CW-1:0] tri_val_o
);

  localparam int            DIST  = band_distance(IDX, HALF);
  localparam logic [FW-1:0] DMASK = FW'((1 << DIST) - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          down_q, down_n;
  logic          step_en;

  // In the variable-frequency mode, outer bands step on every 2^DIST-th tick only.
  assign step_en = tick_i &&
                   ((mode_act_i != MODE_VSF) || ((frame_pos_i & DMASK) == '0));

  always_comb begin
    cnt_n  = cnt_q;
    down_n = down_q;
    if (frame_end_i) begin
      if (phase_inverted(mode_nxt_i, IDX, HALF)) begin
        cnt_n  = CW'(CAR_MAX);
        down_n = 1'b1;
      end else begin
        cnt_n  = '0;
        down_n = 1'b0;
      end
    end else if (step_en) begin
      if (!down_q) begin
        cnt_n = cnt_q + CW'(1);
        if (cnt_q == CW'(CAR_MAX - 1)) down_n = 1'b1;
      end else begin
        cnt_n = cnt_q - CW'(1);
        if (cnt_q == CW'(1)) down_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      down_q <= down_n;
    end
  end

  assign tri_val_o = cnt_q;

endmodule

// File: rtl/lvlshift_pwm_cmp.sv
module lvlshift_pwm_cmp #(
  parameter int NCAR    = 6,
  parameter int HALF    = 3,
  parameter int CAR_MAX = 16,
  parameter int CW      = 5,
  parameter int REF_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic signed [REF_W-1:0]    ref_smp_i,
  input  logic [NCAR-1:0][CW-1:0]    tri_val_i,
  output logic [NCAR-1:0]            cmp_o
);

  logic [NCAR-1:0] cmp_q, cmp_n;

  always_comb begin
    int car;
    for (int k = 0; k < NCAR; k++) begin
      car      = (k - HALF) * CAR_MAX + int'(tri_val_i[k]);
      cmp_n[k] = (int'(ref_smp_i) > car);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= '0;
    else        cmp_q <= cmp_n;
  end

  assign cmp_o = cmp_q;

endmodule

// File: rtl/lvlshift_pwm_level.sv
module lvlshift_pwm_level #(
  parameter int NCAR = 6,
  parameter int HALF = 3,
  parameter int LW   = 3
) (
  input  logic [NCAR-1:0]       cmp_i,
  output logic signed [LW-1:0]  level_o
);

  always_comb begin
    int ones;
    ones = 0;
    for (int k = 0; k < NCAR; k++) ones = ones + int'(cmp_i[k]);
    level_o = LW'(ones - HALF);
  end

endmodule

// File: rtl/lvlshift_pwm.sv
module lvlshift_pwm
  import lvlshift_pwm_pkg::*;
#(
  parameter int LEVELS  = 7,
  parameter int CAR_MAX = 16,
  parameter int PRESC   = 2,
  parameter int REF_W   = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [1:0]                             mode_sel,
  input  logic signed [REF_W-1:0]                ref_smp,
  output logic [LEVELS-2:0]                      cmp_o,
  output logic signed [$clog2((LEVELS-1)/2+1):0] level_o
);

  localparam int NCAR  = LEVELS - 1;
  localparam int HALF  = NCAR / 2;
  localparam int CW    = $clog2(CAR_MAX + 1);
  localparam int LW    = $clog2(HALF + 1) + 1;
  localparam int FRAME = 2 * CAR_MAX * (1 << (HALF - 1));
  localparam int FW    = $clog2(FRAME);
  localparam int PW    = $clog2(PRESC);

  logic                    tick;
  logic                    frame_end;
  logic [FW-1:0]           frame_pos;
  carmode_e                mode_act, mode_act_n, mode_req;
  logic [NCAR-1:0][CW-1:0] tri_val;

  assign mode_req = carmode_e'(mode_sel);

  always_comb begin
    mode_act_n = mode_act;
    if (frame_end) mode_act_n = mode_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_act <= MODE_PD;
    else        mode_act <= mode_act_n;
  end

  lvlshift_pwm_tick #(
    .PRESC(PRESC), .FRAME(FRAME), .PW(PW), .FW(FW)
  ) u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_o     (tick),
    .frame_end_o(frame_end),
    .frame_pos_o(frame_pos)
  );

  for (genvar k = 0; k < NCAR; k++) begin : g_car
    lvlshift_pwm_carrier #(
      .IDX(k), .HALF(HALF), .CAR_MAX(CAR_MAX), .CW(CW), .FW(FW)
    ) u_car (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick),
      .frame_end_i(frame_end),
      .frame_pos_i(frame_pos),
      .mode_act_i (mode_act),
      .mode_nxt_i (mode_req),
      .tri_val_o  (tri_val[k])
    );
  end

  lvlshift_pwm_cmp #(
    .NCAR(NCAR), .HALF(HALF), .CAR_MAX(CAR_MAX), .CW(CW), .REF_W(REF_W)
  ) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_smp_i(ref_smp),
    .tri_val_i(tri_val),
    .cmp_o    (cmp_o)
  );

  lvlshift_pwm_level #(
    .NCAR(NCAR), .HALF(HALF), .LW(LW)
  ) u_level (
    .cmp_i  (cmp_o),
    .level_o(level_o)
  );

endmodule

// File: rtl/lvlshift_pwm_chk.sv
module lvlshift_pwm_chk #(
  parameter int NCAR    = 6,
  parameter int HALF    = 3,
  parameter int CAR_MAX = 16,
  parameter int REF_W   = 8,
  parameter int LW      = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [1:0]              mode_sel,
  input logic signed [REF_W-1:0] ref_smp,
  input logic [NCAR-1:0]         cmp,
  input logic signed [LW-1:0]    level,
  input logic [1:0]              mode_act,
  input logic                    frame_end
);

  localparam int TOP = HALF * CAR_MAX;

  // R3: stacked bands yield a thermometer code
  assert_thermo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp & (cmp + NCAR'(1))) == '0);

  // R3: reference above the highest band sets every bit
  assert_top_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(ref_smp) > TOP) |=> (&cmp));

  // R3: reference at or below the lowest band clears every bit
  assert_bot_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(ref_smp) <= -TOP) |=> (cmp == '0));

  // R4: level code tracks the comparator population
  assert_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) == ($countones(cmp) - HALF));

  // R9: active mode holds between frame ends
  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(mode_act));

  // R9: active mode is loaded from the request at a frame end
  assert_mode_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (mode_act == $past(mode_sel)));

endmodule

bind lvlshift_pwm lvlshift_pwm_chk #(
  .NCAR(NCAR), .HALF(HALF), .CAR_MAX(CAR_MAX), .REF_W(REF_W), .LW(LW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_sel (mode_sel),
  .ref_smp  (ref_smp),
  .cmp      (cmp_o),
  .level    (level_o),
  .mode_act (mode_act),
  .frame_end(frame_end)
);

// File: tb/lvlshift_pwm_bench.sv
module lvlshift_pwm_bench;

  localparam int LEVELS = 7;
  localparam int NCAR   = LEVELS - 1;
  localparam int HALF   = NCAR / 2;
  localparam int CM     = 16;
  localparam int PRESC  = 2;
  localparam int FRAME  = 2 * CM * (1 << (HALF - 1));

  logic              clk;
  logic              rst_n;
  logic [1:0]        mode_sel;
  logic signed [7:0] ref_smp;
  logic [NCAR-1:0]   cmp_o;
  logic signed [2:0] level_o;

  int total = 0;
  int bad   = 0;
  int nedge = 0;
  int mdl_mode = 0;
  int ramp = -52;
  bit done = 0;

  lvlshift_pwm #(.LEVELS(LEVELS), .CAR_MAX(CM), .PRESC(PRESC), .REF_W(8)) u_lvlshift_pwm (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ref_smp(ref_smp),
    .cmp_o(cmp_o), .level_o(level_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Carrier k value after f ticks of the current frame under mode m.
  function automatic int carrier_model(int k, int m, int f);
    int d, steps, p, t;
    bit inv;
    d   = (k < HALF) ? (HALF - 1 - k) : (k - HALF);
    inv = (m == 1) ? (k < HALF) : ((m == 2) ? ((k % 2) == 1) : 1'b0);
    steps = (m == 3) ? ((f + (1 << d) - 1) >> d) : f;
    p = steps % (2 * CM);
    t = (p <= CM) ? p : (2 * CM - p);
    if (inv) t = CM - t;
    return (k - HALF) * CM + t;
  endfunction

  task automatic check_vec(string tag, logic [NCAR-1:0] act, logic [NCAR-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cmp=%b expected=%b at edge %0d", tag, act, exp, nedge);
    end
  endtask

  task automatic check_int(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s value=%0d expected=%0d at edge %0d", tag, act, exp, nedge);
    end
  endtask

  // Advance one clock edge and compare against the model; R2 timing is implied.
  task automatic step(string tag);
    int f_prev, t_new;
    logic [NCAR-1:0] exp_c;
    f_prev = (nedge / PRESC) % FRAME;
    @(negedge clk);
    nedge++;
    for (int k = 0; k < NCAR; k++)
      exp_c[k] = (int'(ref_smp) > carrier_model(k, mdl_mode, f_prev));
    check_vec(tag, cmp_o, exp_c);
    check_int("R4 level", int'(level_o), $countones(exp_c) - HALF);
    t_new = nedge / PRESC;
    if ((nedge % PRESC) == 0 && (t_new % FRAME) == 0) mdl_mode = int'(mode_sel);
  endtask

  task automatic next_ramp(int inc);
    ramp = ramp + inc;
    if (ramp > 52) ramp = ramp - 105;
    ref_smp = 8'(ramp);
  endtask

  task automatic test_reset();
    rst_n = 1'b0; mode_sel = 2'd0; ref_smp = 8'sd100;
    repeat (4) @(negedge clk);
    check_vec("R1 in reset", cmp_o, '0);
    check_int("R1 level in reset", int'(level_o), -HALF);
    rst_n = 1'b1;
    check_vec("R1 after release", cmp_o, '0);
    check_int("R1 level after release", int'(level_o), -HALF);
  endtask

  task automatic test_static();
    ref_smp = 8'sd100; step("R3 high"); step("R3 high");
    check_vec("R3 all ones", cmp_o, '1);
    check_int("R4 top level", int'(level_o), HALF);
    ref_smp = 8'sd49; step("R3 just above"); step("R3 just above");
    check_vec("R3 above top band", cmp_o, '1);
    ref_smp = -8'sd48; step("R3 bottom edge"); step("R3 bottom edge");
    check_vec("R3 equal bottom gives zeros", cmp_o, '0);
    ref_smp = -8'sd100; step("R3 low"); step("R3 low");
    check_vec("R3 all zeros", cmp_o, '0);
    check_int("R4 bottom level", int'(level_o), -HALF);
  endtask

  task automatic test_mode(logic [1:0] m, string tag, int inc);
    mode_sel = m;
    repeat (3 * PRESC * FRAME) begin
      step(tag);
      next_ramp(inc);
    end
    check_int({tag, " mode taken"}, mdl_mode, int'(m));
  endtask

  task automatic test_switch();
    mode_sel = 2'd3;
    repeat (PRESC * FRAME + 40) begin step("R9 mid-frame request"); next_ramp(3); end
    mode_sel = 2'd1;
    repeat (60) begin step("R9 pending not yet active"); next_ramp(3); end
    while (((nedge + 1) % (PRESC * FRAME)) != 0) begin
      step("R9 before boundary"); next_ramp(3);
    end
    mode_sel = 2'd2;
    step("R9 boundary edge");
    mode_sel = 2'd0;
    check_int("R9 boundary sample", mdl_mode, 2);
    repeat (PRESC * FRAME) begin step("R9 after boundary R7"); next_ramp(5); end
  endtask

  initial begin
    test_reset();
    test_static();
    test_mode(2'd0, "R5 in phase", 3);
    test_mode(2'd1, "R6 opposed", 5);
    test_mode(2'd2, "R7 alternate", 7);
    test_mode(2'd3, "R8 variable freq", 3);
    test_switch();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule